// File: doc/BRIEF.md
# Timer Compare Channel with Pulse Output

This block is one output-compare channel attached to a free-running time counter. The counter is an input and wraps modulo 2^CW. Software arms an event time in the compare register. When the counter reaches that time, or steps past it, the channel sets an event flag. It can raise an interrupt, and it drives its output pin in the way a 4-bit mode code selects.

The compare register is double-buffered. A second event time written while one is already armed is held back. It becomes the active target only once the armed event has fired, so software can stay one event ahead. This is how a continuous one-pulse-per-period output is produced.

Writes go through a single write port that selects either the control/status register or the compare register. The control/status register and the active compare value are always visible on read-back outputs.

Top module: `tcmp_channel`

## Requirements
- R1: After reset, the control read-back is 0x00, the compare read-back is 0, and `pin_o` and `irq_o` are low.
- R2: A write with `wr_addr_i`=0 targets the control register and updates these fields: bit 6 (interrupt enable), bits [5:2] (mode) and bit 0 (DMA-request enable, stored only). These fields read back on `ctrl_rd_o` in the next cycle. Bit 1 always reads 0, and a written bit 7 never sets the flag.
- R3: A match occurs in a cycle where the mode is non-zero, a value is armed, and the armed value C lies in the window (P, N] taken modulo 2^CW. Here P is the counter value of the previous cycle and N is the current `count_i`. This covers exact equality, steps larger than 1, and counter wrap. A match sets flag bit 7 at the clock edge that ends that cycle.
- R4: Writing the control register with bit 7 = 1 clears the flag, and writing bit 7 = 0 leaves it unchanged. When a match and a clearing write happen in the same cycle, the flag ends up set.
- R5: `irq_o` is high exactly while both the flag and the interrupt enable are set.
- R6: In mode 0xF, `pin_o` is high for exactly one clock after a match and low otherwise.
- R7: In mode 0x5, `pin_o` inverts on every match.
- R8: Mode 0x7 drives `pin_o` high on a match, and mode 0x6 drives it low on a match. Mode 0x4, and every other non-zero code, only sets the flag and leaves `pin_o` unchanged.
- R9: A write with `wr_addr_i`=1 loads a compare value. If nothing is armed, the value is armed and shows on `cmp_rd_o`. If a value is already armed, the new value goes into a single holding slot and replaces any value waiting there. On a match, the held value becomes armed. If nothing is held, the channel goes idle: `cmp_rd_o` reads 0 and no further match occurs.
- R10: Mode 0 disables the channel. No match occurs, and `pin_o` is low from the cycle after the mode reads 0. Compare writes are still accepted and are not consumed. Any control write with mode 0 discards both the armed value and the held value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | CW | Current time-counter value |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = control/status, 1 = compare |
| wr_data_i | input | CW | Write data (control uses bits [7:0]) |
| ctrl_rd_o | output | 8 | Control/status read-back |
| cmp_rd_o | output | CW | Armed compare value, 0 when idle |
| irq_o | output | 1 | Interrupt request |
| pin_o | output | 1 | Compare output pin |

## Verification
Matching is driven with a counter that steps by 7, so it passes the target without ever equalling it. It is also driven with exact hits and with a jump across the wrap point. Together these show that the window test, rather than a plain equality test, catches each event. Each pin mode gets its own sequence, which separates a one-clock pulse from a level change, a toggle and a flag-only event. A second match with and without a held value shows whether promotion happens or the channel idles. A clearing write placed in the same cycle as a match shows which of the two wins.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  localparam int CTRL_W  = 8;
  localparam int FLAG_B  = 7;
  localparam int IE_B    = 6;
  localparam int MODE_HI = 5;
  localparam int MODE_LO = 2;
  localparam int DRE_B   = 0;

  typedef enum logic [3:0] {
    MODE_OFF     = 4'h0,
    MODE_FLAG    = 4'h4,
    MODE_TOGGLE  = 4'h5,
    MODE_CLEAR   = 4'h6,
    MODE_SET     = 4'h7,
    MODE_HIPULSE = 4'hF
  } pin_mode_e;

  typedef struct packed {
    logic       flag;
    logic       ie;
    logic [3:0] mode;
    logic       rsvd;
    logic       dre;
  } ctrl_t;

  // Next pin level from mode, current level and match event.
  function automatic logic pin_next(input logic [3:0] mode, input logic cur, input logic hit);
    logic nxt;
    nxt = cur;
    if (mode == MODE_OFF) begin
      nxt = 1'b0;
    end else if (hit) begin
      case (mode)
        MODE_HIPULSE: nxt = 1'b1;
        MODE_TOGGLE:  nxt = ~cur;
        MODE_CLEAR:   nxt = 1'b0;
        MODE_SET:     nxt = 1'b1;
        default:      nxt = cur;
      endcase
    end else if (mode == MODE_HIPULSE) begin
      nxt = 1'b0;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/tcmp_regs.sv
module tcmp_regs
  import tcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wr_flag,
  input  logic       wr_ie,
  input  logic [3:0] wr_mode,
  input  logic       wr_dre,
  input  logic       hit,
  output ctrl_t      ctrl_o
);

  logic       flag_q, ie_q, dre_q;
  logic [3:0] mode_q;
  logic       clr_req;

  assign clr_req = wr_ctrl && wr_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      mode_q <= MODE_OFF;
      dre_q  <= 1'b0;
    end else begin
      if (hit)          flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
      if (wr_ctrl) begin
        ie_q   <= wr_ie;
        mode_q <= wr_mode;
        dre_q  <= wr_dre;
      end
    end
  end

  assign ctrl_o = '{flag: flag_q, ie: ie_q, mode: mode_q, rsvd: 1'b0, dre: dre_q};

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !hit) |=> !flag_q);
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !hit) |=> $stable(flag_q));

endmodule

// File: rtl/tcmp_cmpbuf.sv
module tcmp_cmpbuf #(
  parameter int CW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmp,
  input  logic [CW-1:0] wr_val,
  input  logic          flush,
  input  logic          hit,
  output logic          arm_v,
  output logic [CW-1:0] arm_val,
  output logic          held_v
);

  logic [CW-1:0] arm_q, held_q, arm_d, held_d;
  logic          arm_v_q, held_v_q, arm_v_d, held_v_d;

  always_comb begin
    arm_v_d  = arm_v_q;
    arm_d    = arm_q;
    held_v_d = held_v_q;
    held_d   = held_q;
    if (flush) begin
      arm_v_d  = 1'b0;
      held_v_d = 1'b0;
    end
    if (hit) begin
      arm_v_d  = held_v_d;
      arm_d    = held_d;
      held_v_d = 1'b0;
    end
    if (wr_cmp) begin
      if (!arm_v_d) begin
        arm_v_d = 1'b1;
        arm_d   = wr_val;
      end else begin
        held_v_d = 1'b1;
        held_d   = wr_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_v_q  <= 1'b0;
      arm_q    <= '0;
      held_v_q <= 1'b0;
      held_q   <= '0;
    end else begin
      arm_v_q  <= arm_v_d;
      arm_q    <= arm_d;
      held_v_q <= held_v_d;
      held_q   <= held_d;
    end
  end

  assign arm_v   = arm_v_q;
  assign arm_val = arm_q;
  assign held_v  = held_v_q;

  p_promote_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && held_v_q && !wr_cmp) |=> (arm_v_q && arm_q == $past(held_q) && !held_v_q));
  p_idle_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !held_v_q && !wr_cmp) |=> !arm_v_q);
  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!arm_v_q && !held_v_q));

endmodule

// File: rtl/tcmp_match.sv
module tcmp_match #(
  parameter int CW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          enable,
  input  logic          arm_v,
  input  logic [CW-1:0] arm_val,
  output logic          hit
);

  logic [CW-1:0] prev_q, d_tgt, d_step;

  // Forward distance from a to b on the wrapping counter.
  function automatic logic [CW-1:0] ahead(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return b - a;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= count;
  end

  assign d_tgt  = ahead(prev_q, arm_val);
  assign d_step = ahead(prev_q, count);
  assign hit    = enable && arm_v && (d_tgt != '0) && (d_tgt <= d_step);

  p_hit_needs_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (count != prev_q));
  p_hit_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !hit);

endmodule

// File: rtl/tcmp_pin.sv
module tcmp_pin
  import tcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode,
  input  logic       hit,
  output logic       pin
);

  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_next(mode, pin_q, hit);
  end

  assign pin = pin_q;

  p_pulse_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HIPULSE && pin_q && !hit) |=> !pin_q);
  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TOGGLE && hit) |=> (pin_q != $past(pin_q)));
  p_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |=> !pin_q);
  p_flag_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FLAG) |=> $stable(pin_q));

endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel
  import tcmp_pkg::*;
#(
  parameter int CW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic          wr_en_i,
  input  logic          wr_addr_i,
  input  logic [CW-1:0] wr_data_i,
  output logic [7:0]    ctrl_rd_o,
  output logic [CW-1:0] cmp_rd_o,
  output logic          irq_o,
  output logic          pin_o
);

  ctrl_t         ctrl;
  logic          wr_ctrl, wr_cmp, flush, hit, enable;
  logic          arm_v, held_v;
  logic [CW-1:0] arm_val;
  logic [3:0]    wr_mode;

  assign wr_ctrl = wr_en_i && !wr_addr_i;
  assign wr_cmp  = wr_en_i && wr_addr_i;
  assign wr_mode = wr_data_i[MODE_HI:MODE_LO];
  assign flush   = wr_ctrl && (wr_mode == MODE_OFF);
  assign enable  = (ctrl.mode != MODE_OFF);

  tcmp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
    .wr_flag(wr_data_i[FLAG_B]), .wr_ie(wr_data_i[IE_B]),
    .wr_mode(wr_mode), .wr_dre(wr_data_i[DRE_B]),
    .hit(hit), .ctrl_o(ctrl)
  );

  tcmp_cmpbuf #(.CW(CW)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_cmp(wr_cmp), .wr_val(wr_data_i),
    .flush(flush), .hit(hit), .arm_v(arm_v), .arm_val(arm_val), .held_v(held_v)
  );

  tcmp_match #(.CW(CW)) u_match (
    .clk(clk), .rst_n(rst_n), .count(count_i), .enable(enable),
    .arm_v(arm_v), .arm_val(arm_val), .hit(hit)
  );

  tcmp_pin u_pin (
    .clk(clk), .rst_n(rst_n), .mode(ctrl.mode), .hit(hit), .pin(pin_o)
  );

  assign ctrl_rd_o = ctrl;
  assign cmp_rd_o  = arm_v ? arm_val : '0;
  assign irq_o     = ctrl.flag && ctrl.ie;

  p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(hit) || $past(wr_ctrl)));
  p_flag_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ctrl_rd_o[FLAG_B]);
  p_held_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    held_v |-> arm_v);

endmodule

// File: tb/tcmp_channel_tb.sv
module tcmp_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic          wr_en_i = 1'b0;
  logic          wr_addr_i = 1'b0;
  logic [CW-1:0] wr_data_i = '0;
  logic [7:0]    ctrl_rd_o;
  logic [CW-1:0] cmp_rd_o;
  logic          irq_o, pin_o;

  int n_chk = 0;
  int n_fail = 0;
  int cur = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcmp_channel #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .ctrl_rd_o(ctrl_rd_o),
    .cmp_rd_o(cmp_rd_o), .irq_o(irq_o), .pin_o(pin_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, sample 1 unit after the posedge.
  task automatic cyc(input int cnt, input bit we, input bit adr, input int data);
    @(negedge clk);
    count_i   = CW'(cnt);
    wr_en_i   = we;
    wr_addr_i = adr;
    wr_data_i = CW'(data);
    cur       = cnt;
    @(posedge clk);
    #1;
  endtask

  task automatic wrctrl(input int v); cyc(cur, 1'b1, 1'b0, v); endtask
  task automatic wrcmp(input int v);  cyc(cur, 1'b1, 1'b1, v); endtask
  task automatic tick(input int v);   cyc(v, 1'b0, 1'b0, 0);   endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1", "ctrl", ctrl_rd_o, 0);
    check("R1", "cmp", cmp_rd_o, 0);
    check("R1", "pin", pin_o, 0);
    check("R1", "irq", irq_o, 0);
  endtask

  task automatic t_ctrl_fields();
    wrctrl(8'h83);
    check("R2", "bit1/bit7 read 0", ctrl_rd_o, 8'h01);
    wrctrl(8'h7D);
    check("R2", "fields", ctrl_rd_o, 8'h7D);
    wrctrl(8'h00);
    check("R2", "cleared", ctrl_rd_o, 8'h00);
  endtask

  task automatic t_pulse_buffer();
    int early;
    early = 0;
    wrcmp(100);
    check("R9", "first write arms", cmp_rd_o, 100);
    wrcmp(300);
    check("R9", "second write held", cmp_rd_o, 100);
    wrctrl(8'h7C);
    for (int v = 7; v <= 105; v += 7) begin
      tick(v);
      if (v < 105 && (pin_o || ctrl_rd_o[7])) early++;
    end
    check("R3", "no early event", early, 0);
    check("R3", "flag on step-over", ctrl_rd_o[7], 1);
    check("R6", "pulse high", pin_o, 1);
    check("R5", "irq", irq_o, 1);
    check("R9", "held promoted", cmp_rd_o, 300);
    tick(112);
    check("R6", "pulse one clock", pin_o, 0);
    wrctrl(8'h7C);
    check("R4", "write 0 keeps flag", ctrl_rd_o[7], 1);
    wrctrl(8'hFC);
    check("R4", "w1c", ctrl_rd_o[7], 0);
    check("R5", "irq drops", irq_o, 0);
    for (int v = 119; v <= 301; v += 7) tick(v);
    check("R6", "second pulse", pin_o, 1);
    check("R9", "idle after last", cmp_rd_o, 0);
    wrctrl(8'hFC);
    early = 0;
    for (int v = 308; v <= 399; v += 7) begin
      tick(v);
      if (ctrl_rd_o[7] || pin_o) early++;
    end
    check("R9", "no match when idle", early, 0);
  endtask

  task automatic t_toggle_wrap();
    wrctrl(8'h54);
    tick(65530);
    wrcmp(3);
    tick(4);
    check("R3", "match across wrap", ctrl_rd_o[7], 1);
    check("R7", "toggle to 1", pin_o, 1);
    wrctrl(8'hD4);
    wrcmp(10);
    wrcmp(20);
    tick(12);
    check("R7", "toggle to 0", pin_o, 0);
    check("R9", "promote 20", cmp_rd_o, 20);
    tick(20);
    check("R3", "exact equality", pin_o, 1);
  endtask

  task automatic t_race();
    wrcmp(40);
    cyc(40, 1'b1, 1'b0, 8'hD4);
    check("R4", "set wins over clear", ctrl_rd_o[7], 1);
    check("R7", "toggle on race match", pin_o, 0);
    wrctrl(8'hD4);
    check("R4", "clear after race", ctrl_rd_o[7], 0);
  endtask

  task automatic t_static_modes();
    wrctrl(8'h1C);
    wrcmp(50);
    tick(50);
    check("R8", "set mode", pin_o, 1);
    check("R5", "no irq without enable", irq_o, 0);
    wrctrl(8'h90);
    wrcmp(60);
    tick(60);
    check("R8", "flag-only keeps pin", pin_o, 1);
    check("R8", "flag-only sets flag", ctrl_rd_o[7], 1);
    wrctrl(8'h98);
    wrcmp(70);
    tick(70);
    check("R8", "clear mode", pin_o, 0);
  endtask

  task automatic t_disable();
    wrctrl(8'h9C);
    wrcmp(80);
    tick(80);
    check("R8", "pin high before disable", pin_o, 1);
    wrctrl(8'h9C);
    wrcmp(90);
    wrcmp(100);
    wrctrl(8'h00);
    check("R10", "values dropped", cmp_rd_o, 0);
    tick(cur);
    check("R10", "pin low when off", pin_o, 0);
    tick(95);
    tick(105);
    check("R10", "no match after drop", ctrl_rd_o[7], 0);
    wrcmp(120);
    tick(130);
    check("R10", "disabled no match", ctrl_rd_o[7], 0);
    check("R10", "value not consumed", cmp_rd_o, 120);
    wrctrl(8'h00);
    check("R10", "mode 0 write drops", cmp_rd_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_ctrl_fields();
    t_pulse_buffer();
    t_toggle_wrap();
    t_race();
    t_static_modes();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule